// File: doc/BRIEF.md
# Shift-Register CAM String Matcher

This block is the match-finding core of a sliding-window dictionary compressor. It takes a byte stream under a valid/ready handshake. It keeps the most recent bytes in two chained shift registers: a look-ahead window of `COLS` bytes and a history grid of `ROWS` x `COLS` bytes. Every accepted byte moves the whole chain by one slot in the same cycle. There is no write address: the oldest history byte simply falls out of the grid.

Once enough history has been collected, the block searches for the longest prefix of the look-ahead window that also occurs in the history. It handles one look-ahead byte per step and compares it against all history positions in parallel. A match matrix with one bit per position records which positions are still extending a run. The next step enables only the comparators whose older neighbour hit, so dead positions cost no comparisons. When the matrix empties, or the run reaches the look-ahead length, the block reports the length and the matrix of run end positions with a one-cycle done pulse. It then takes one new byte for a short run, or one byte per matched byte for a long run, and starts the next search. Turning the result into offsets and tokens is left to the block downstream.

Top module: `srcm_matcher`

## Requirements
- R1: `in_ready_o` is high exactly while the block waits for stream bytes. A byte is taken on a rising edge where both `in_valid_i` and `in_ready_o` are high. With `in_valid_i` low, no byte is taken and no search starts.
- R2: Each accepted byte enters look-ahead slot `COLS-1`. Look-ahead slot 0 moves to history position `SB-1` (the newest), and history position 0 (the oldest) is dropped, where `SB = ROWS*COLS`. History positions are numbered row-major, p = row*COLS + col, and both shifting and matching carry from the last column of a row into the first column of the next row.
- R3: After reset, no search starts until `SB+COLS` bytes have been accepted.
- R4: Let history byte p be h[p] and look-ahead byte j be a[j]. The reported length L is the largest count r, up to `COLS`, such that h[s+j] = a[j] for all j < r at some start s with s+r <= SB. A run that reaches position `SB-1` stops there without ending the runs still growing at other positions.
- R5: In `match_mat_o`, bit p is 1 exactly when a run of length L ends at position p, that is, when p = s+L-1 for a start s that reaches length L. The matrix is all zero when L = 0.
- R6: Each look-ahead byte takes two cycles: one to compare and one to test the matrix for all zero. `done_o` is first high 2L+2 clock edges after the edge that accepted the last byte when L < `COLS`, and 2*`COLS` edges after it when L = `COLS`.
- R7: `done_o` is high for one cycle per search. `match_len_o` and `match_mat_o` change only on the edge that raises `done_o` and hold their values until the next result.
- R8: After a result, the block accepts exactly 1 byte before the next search when L < `MIN_MATCH` (default 4), and exactly L bytes otherwise.
- R9: The length is `LEN_W` bits wide (default 8) and is capped at the look-ahead length `COLS`.
- R10: The controller is a Moore machine whose state register is one-hot at all times.
- R11: While and after the asynchronous active-low reset, `done_o` is 0, `match_len_o` is 0, `match_mat_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Stream byte offered |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Block can take a byte this cycle |
| done_o | output | 1 | One-cycle pulse: a new result is on the outputs |
| match_len_o | output | LEN_W | Longest run length found |
| match_mat_o | output | ROWS*COLS | Run end positions, one bit per history position |

## Verification
Two decisions can fall on the same test cycle: reaching the length cap and finding the matrix empty both happen at look-ahead step `COLS-1`. A run can also reach the newest history position in the same compare where other runs keep growing. Constant and short-period segments drive runs to the cap and across the end of the grid. Random and small-alphabet segments end searches at every step. A reference model rebuilt from the accepted-byte history judges each result for length, matrix, latency from the last accepted byte, and the number of bytes taken before it.

// File: rtl/srcm_pkg.sv
package srcm_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam int unsigned ST_W     = 4;
  localparam int unsigned SI_SHIFT = 0;
  localparam int unsigned SI_CMP   = 1;
  localparam int unsigned SI_TEST  = 2;
  localparam int unsigned SI_DONE  = 3;

  typedef enum logic [ST_W-1:0] {
    ST_SHIFT = 4'b0001,
    ST_CMP   = 4'b0010,
    ST_TEST  = 4'b0100,
    ST_DONE  = 4'b1000
  } ctrl_st_e;
endpackage

// File: rtl/srcm_grid.sv
module srcm_grid
  import srcm_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8,
  localparam int unsigned SB    = ROWS * COLS,
  localparam int unsigned IDX_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  byte_t            data_i,
  input  logic             cmp_i,
  input  logic             first_i,
  input  logic [IDX_W-1:0] step_i,
  output logic [SB-1:0]    mat_o,
  output logic [SB-1:0]    prev_mat_o
);

  byte_t          sb_q [SB];
  byte_t          la_q [COLS];
  byte_t          la_byte;
  logic [SB-1:0]  mat_q, prev_q, mat_d;

  // whole chain moves one slot per accepted byte; position 0 is oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SB; i++)   sb_q[i] <= '0;
      for (int j = 0; j < COLS; j++) la_q[j] <= '0;
    end else if (shift_i) begin
      for (int i = 0; i < SB - 1; i++)   sb_q[i] <= sb_q[i+1];
      sb_q[SB-1] <= la_q[0];
      for (int j = 0; j < COLS - 1; j++) la_q[j] <= la_q[j+1];
      la_q[COLS-1] <= data_i;
    end
  end

  assign la_byte = la_q[step_i];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned P = r * COLS + c;
      logic en;
      if (P == 0) begin : g_head
        // no older neighbour: may only open a run
        assign en = first_i;
      end else if (c == 0) begin : g_wrap
        // predecessor is last column of the previous row
        assign en = first_i | mat_q[(r-1)*COLS + COLS - 1];
      end else begin : g_in
        assign en = first_i | mat_q[P-1];
      end
      assign mat_d[P] = en && (sb_q[P] == la_byte);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mat_q  <= '0;
      prev_q <= '0;
    end else if (cmp_i) begin
      mat_q  <= mat_d;
      prev_q <= first_i ? '0 : mat_q;
    end
  end

  assign mat_o      = mat_q;
  assign prev_mat_o = prev_q;

endmodule

// File: rtl/srcm_ctrl.sv
module srcm_ctrl
  import srcm_pkg::*;
#(
  parameter int unsigned SB        = 32,
  parameter int unsigned LA        = 8,
  parameter int unsigned MIN_MATCH = 4,
  parameter int unsigned LEN_W     = 8,
  localparam int unsigned FILL   = SB + LA,
  localparam int unsigned FILL_W = $clog2(FILL + 1),
  localparam int unsigned IDX_W  = (LA > 1) ? $clog2(LA) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             mat_any_i,
  output logic             in_ready_o,
  output logic             shift_o,
  output logic             cmp_o,
  output logic             first_o,
  output logic [IDX_W-1:0] step_o,
  output logic             done_o,
  output logic             cap_o,
  output logic             cap_cur_o,
  output logic [LEN_W-1:0] len_o,
  output ctrl_st_e         state_o
);

  ctrl_st_e          st_q, st_d;
  logic [FILL_W-1:0] fill_q;
  logic [IDX_W-1:0]  step_q;
  logic [LEN_W-1:0]  adv_q, len_q;
  logic              take, hist_ok, last_adv, step_last, finish;

  assign take      = st_q[SI_SHIFT] && in_valid_i;
  assign hist_ok   = fill_q >= FILL_W'(FILL - 1);
  assign last_adv  = adv_q <= LEN_W'(1);
  assign step_last = step_q == IDX_W'(LA - 1);
  assign finish    = st_q[SI_TEST] && (!mat_any_i || step_last);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SHIFT: if (take && last_adv && hist_ok) st_d = ST_CMP;
      ST_CMP:   st_d = ST_TEST;
      ST_TEST:  st_d = (!mat_any_i || step_last) ? ST_DONE : ST_CMP;
      ST_DONE:  st_d = ST_SHIFT;
      default:  st_d = ST_SHIFT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SHIFT;
      fill_q <= '0;
      step_q <= '0;
      adv_q  <= '0;
      len_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        if (fill_q != FILL_W'(FILL)) fill_q <= fill_q + FILL_W'(1);
        if (adv_q != '0) adv_q <= adv_q - LEN_W'(1);
      end
      if (st_q[SI_SHIFT]) step_q <= '0;
      else if (st_q[SI_TEST] && !finish) step_q <= step_q + IDX_W'(1);
      if (finish) len_q <= mat_any_i ? LEN_W'(LA) : LEN_W'(step_q);
      if (st_q[SI_DONE]) adv_q <= (len_q < LEN_W'(MIN_MATCH)) ? LEN_W'(1) : len_q;
    end
  end

  assign in_ready_o = st_q[SI_SHIFT];
  assign shift_o    = take;
  assign cmp_o      = st_q[SI_CMP];
  assign first_o    = step_q == '0;
  assign step_o     = step_q;
  assign done_o     = st_q[SI_DONE];
  assign cap_o      = finish;
  assign cap_cur_o  = mat_any_i;
  assign len_o      = len_q;
  assign state_o    = st_q;

endmodule

// File: rtl/srcm_matcher.sv
module srcm_matcher
  import srcm_pkg::*;
#(
  parameter int unsigned ROWS      = 4,
  parameter int unsigned COLS      = 8,
  parameter int unsigned MIN_MATCH = 4,
  parameter int unsigned LEN_W     = 8,
  localparam int unsigned SB    = ROWS * COLS,
  localparam int unsigned IDX_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             done_o,
  output logic [LEN_W-1:0] match_len_o,
  output logic [SB-1:0]    match_mat_o
);

  logic             shift, cmp, first, cap, cap_cur;
  logic [IDX_W-1:0] step;
  logic [SB-1:0]    mat, prev_mat, res_mat_q;
  ctrl_st_e         ctrl_state;

  srcm_ctrl #(
    .SB(SB), .LA(COLS), .MIN_MATCH(MIN_MATCH), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .mat_any_i  (|mat),
    .in_ready_o (in_ready_o),
    .shift_o    (shift),
    .cmp_o      (cmp),
    .first_o    (first),
    .step_o     (step),
    .done_o     (done_o),
    .cap_o      (cap),
    .cap_cur_o  (cap_cur),
    .len_o      (match_len_o),
    .state_o    (ctrl_state)
  );

  srcm_grid #(
    .ROWS(ROWS), .COLS(COLS)
  ) u_grid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .data_i     (in_data_i),
    .cmp_i      (cmp),
    .first_i    (first),
    .step_i     (step),
    .mat_o      (mat),
    .prev_mat_o (prev_mat)
  );

  // capped run keeps live matrix; exhausted run keeps the last non-empty one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  res_mat_q <= '0;
    else if (cap) res_mat_q <= cap_cur ? mat : prev_mat;
  end

  assign match_mat_o = res_mat_q;

endmodule

// File: rtl/srcm_checker.sv
module srcm_checker #(
  parameter int unsigned SB    = 32,
  parameter int unsigned LA    = 8,
  parameter int unsigned LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_i,
  input logic             done_i,
  input logic [LEN_W-1:0] match_len_i,
  input logic [SB-1:0]    match_mat_i,
  input logic [3:0]       state_i
);

  a_r10_onehot_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_i) == 1);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r1_no_ready_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !in_ready_i);

  a_r8_resume_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> in_ready_i);

  a_r9_len_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (match_len_i <= LEN_W'(LA)));

  a_r5_empty_mat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && match_len_i == '0) |-> (match_mat_i == '0));

  a_r7_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(match_len_i) |-> done_i);

  a_r7_mat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(match_mat_i) |-> done_i);

endmodule

bind srcm_matcher srcm_checker #(
  .SB(SB), .LA(COLS), .LEN_W(LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_i  (in_ready_o),
  .done_i      (done_o),
  .match_len_i (match_len_o),
  .match_mat_i (match_mat_o),
  .state_i     (ctrl_state)
);

// File: tb/srcm_matcher_tb.sv
`timescale 1ns/1ps
module srcm_matcher_tb;
  import srcm_pkg::*;

  localparam int unsigned ROWS = 4, COLS = 8, MIN_MATCH = 4, LEN_W = 8;
  localparam int unsigned SB = ROWS * COLS, LA = COLS, FILL = SB + LA;
  localparam int unsigned HMAX = 1024;

  localparam logic [7:0] K_RAND = 8'd0, K_PER = 8'd1, K_CONST = 8'd2, K_SMALL = 8'd3;
  localparam int unsigned N_SEG = 9;
  // {kind, count, arg}
  localparam logic [23:0] SEG_TAB [N_SEG] = '{
    {K_RAND,  8'd48, 8'h00},
    {K_PER,   8'd40, 8'd5},
    {K_SMALL, 8'd60, 8'h00},
    {K_CONST, 8'd40, 8'h41},
    {K_RAND,  8'd30, 8'h00},
    {K_PER,   8'd44, 8'd12},
    {K_SMALL, 8'd50, 8'h00},
    {K_PER,   8'd30, 8'd3},
    {K_RAND,  8'd20, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  byte_t in_data = '0;
  logic in_ready, done;
  logic [LEN_W-1:0] match_len;
  logic [SB-1:0] match_mat;

  always #4 clk = ~clk;

  srcm_matcher #(.ROWS(ROWS), .COLS(COLS), .MIN_MATCH(MIN_MATCH), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .done_o(done), .match_len_o(match_len), .match_mat_o(match_mat)
  );

  int checks = 0, fails = 0;
  byte_t stream [HMAX];
  int n_stream = 0;
  byte_t hist [HMAX];
  int n = 0, acc_since = 0, exp_adv = 1, cyc = 0, last_acc = 0, done_cnt = 0;
  logic first_run = 1'b1, prev_done = 1'b0;
  logic [LEN_W-1:0] held_len = '0;
  logic [SB-1:0] held_mat = '0;
  int seen_cap = 0, seen_short = 0, seen_zero = 0, last_len = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(output int l, output logic [SB-1:0] m);
    int runs [SB];
    int base;
    base = n - int'(FILL);
    l = 0;
    m = '0;
    for (int s = 0; s < int'(SB); s++) begin
      int r = 0;
      while (r < int'(LA) && s + r < int'(SB) && hist[base+s+r] == hist[n-int'(LA)+r]) r++;
      runs[s] = r;
      if (r > l) l = r;
    end
    if (l > 0)
      for (int s = 0; s < int'(SB); s++)
        if (runs[s] >= l) m[s+l-1] = 1'b1;
  endtask

  task automatic observe();
    int el, lat, elat;
    logic [SB-1:0] em;
    if (done) begin
      chk(!prev_done, "R7", "done pulse width", 64'(prev_done), 64'd0);
      model(el, em);
      chk(match_len == LEN_W'(el), "R4", "length", 64'(match_len), 64'(el));
      chk(match_mat == em, "R5", "matrix", 64'(match_mat), 64'(em));
      lat  = cyc - last_acc;
      elat = (el == int'(LA)) ? 2 * int'(LA) + 1 : 2 * el + 3;
      chk(lat == elat, "R6", "latency (negedges)", 64'(lat), 64'(elat));
      if (first_run) chk(n == int'(FILL), "R3", "bytes before first search", 64'(n), 64'(FILL));
      else           chk(acc_since == exp_adv, "R8", "bytes between searches", 64'(acc_since), 64'(exp_adv));
      exp_adv   = (el < int'(MIN_MATCH)) ? 1 : el;
      acc_since = 0;
      first_run = 1'b0;
      held_len  = match_len;
      held_mat  = match_mat;
      last_len  = int'(match_len);
      done_cnt++;
      if (el == int'(LA)) seen_cap++;
      if (el > 0 && el < int'(MIN_MATCH)) seen_short++;
      if (el == 0) seen_zero++;
    end else begin
      chk(match_len == held_len && match_mat == held_mat, "R7", "outputs held",
          {match_len, match_mat}, {held_len, held_mat});
    end
    prev_done = done;
  endtask

  task automatic step_cycle(input logic v, input byte_t d, output logic acc);
    @(negedge clk);
    cyc++;
    observe();
    in_valid = v;
    in_data  = d;
    acc = v && in_ready;
    if (acc) begin
      hist[n] = d;
      n++;
      acc_since++;
      last_acc = cyc;
    end
  endtask

  task automatic idle(input int k);
    logic a;
    for (int i = 0; i < k; i++) step_cycle(1'b0, 8'h00, a);
  endtask

  task automatic feed(input byte_t d);
    logic a;
    a = 1'b0;
    while (!a) step_cycle(1'b1, d, a);
  endtask

  task automatic model_reset();
    n = 0; acc_since = 0; exp_adv = 1; first_run = 1'b1; prev_done = 1'b0;
    held_len = '0; held_mat = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int saved;
    for (int e = 0; e < int'(N_SEG); e++) begin
      for (int i = 0; i < int'(SEG_TAB[e][15:8]); i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (SEG_TAB[e][23:16])
          K_PER:   stream[n_stream] = 8'h30 + 8'(i % int'(SEG_TAB[e][7:0]));
          K_CONST: stream[n_stream] = SEG_TAB[e][7:0];
          K_SMALL: stream[n_stream] = 8'h61 + {6'd0, lfsr[1:0]};
          default: stream[n_stream] = lfsr[7:0];
        endcase
        n_stream++;
      end
    end

    // R11: state during reset
    repeat (2) @(negedge clk);
    chk(!done && match_len == '0 && match_mat == '0 && in_ready, "R11", "reset outputs",
        {done, in_ready, match_len}, {1'b0, 1'b1, 8'd0});
    rst_n = 1'b1;

    // main walk: table-built stream with periodic valid gaps (R1, R2)
    for (int i = 0; i < n_stream; i++) begin
      if (i % 7 == 3) idle(1);
      feed(stream[i]);
    end
    idle(40);

    // R1: valid low takes nothing and starts nothing
    saved = done_cnt;
    idle(25);
    chk(done_cnt == saved, "R1", "dones while idle", 64'(done_cnt), 64'(saved));
    chk(in_ready, "R1", "ready while waiting", 64'(in_ready), 64'd1);

    // R11: reset mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk(!done && match_len == '0 && match_mat == '0 && in_ready, "R11", "mid-run reset outputs",
        {done, in_ready, match_len}, {1'b0, 1'b1, 8'd0});
    rst_n = 1'b1;
    model_reset();

    // R3: one byte short of a full window never searches
    for (int i = 0; i < int'(FILL) - 1; i++) feed(8'h77);
    saved = done_cnt;
    idle(30);
    chk(done_cnt == saved, "R3", "search before window full", 64'(done_cnt), 64'(saved));
    feed(8'h77);
    idle(30);
    chk(done_cnt == saved + 1, "R3", "search once window full", 64'(done_cnt), 64'(saved + 1));
    chk(last_len == int'(LA), "R9", "capped length", 64'(last_len), 64'(LA));

    chk(seen_cap > 0, "R9", "cap reached in stream", 64'(seen_cap), 64'd1);
    chk(seen_short > 0, "R8", "short run seen", 64'(seen_short), 64'd1);
    chk(seen_zero > 0, "R5", "empty result seen", 64'(seen_zero), 64'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule